// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Self-Advancing Compare

This block keeps a 64-bit up-counter that advances once every (prescale + 1) clock cycles while it is switched on. A 64-bit compare value sits beside it. When the counter steps onto that value and comparison is switched on, a sticky event flag sets. If the interrupt is allowed, the interrupt output then stays high until software clears the flag.

In the periodic mode, every hit adds a 32-bit step to the compare value, and the counter keeps running without a pause. The block therefore gives a steady train of events with no software work after set-up. In the one-shot mode the compare value stays where software put it.

Software reaches the block through a plain 32-bit register port with a byte address, a write strobe, write data and read data. Read data comes back one clock after the address is presented.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register byte offsets are: 0x00 counter bits [31:0], 0x04 counter bits [63:32], 0x08 control, 0x0C status, 0x10 compare bits [31:0], 0x14 compare bits [63:32], 0x18 step. `bus_rdata` shows the register addressed one clock earlier. While the run bit is 0, the counter holds its value, and both counter words can still be written and read back.
- R3: Control bit 0 is run and bits [15:8] are the prescale value P. While run is 1, the counter increases by one every P+1 clocks. The internal divider restarts from zero whenever run is 0.
- R4: The counter is one 64-bit quantity: a carry out of bits [31:0] increments bits [63:32].
- R5: Control bit 1 enables comparison. An event occurs only when the counter advances onto a value equal to the whole 64-bit compare value while comparison is enabled. Writing the counter to a value equal to the compare value raises no event.
- R6: Status bit 0 is the event flag. An event sets it, and it stays set. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R7: Control bit 2 allows the interrupt. `irq_o` is high exactly while the event flag is set and this bit is 1.
- R8: With control bit 3 at 0 (one-shot), an event leaves the compare value unchanged.
- R9: With control bit 3 at 1 (periodic), each event adds the 32-bit step to the 64-bit compare value modulo 2^64, and the counter keeps counting.
- R10: Control bits [31:16] and [7:4], status bits [31:1], and unmapped offsets read as zero. Writes to these bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the address |
| irq_o | output | 1 | Interrupt, high while the flag is set and the interrupt is allowed |

## Verification
The step and hold assertions assume that the prescale field, the step and the compare words are not rewritten in the same clock as the event they are checked against. The bench keeps to this by changing the configuration only while the run bit is 0. The stimulus also assumes that software writes whole 32-bit words to word-aligned offsets. Each test sets the counter, the compare value and the step while the block is stopped, runs it for a counted number of clocks, and stops it again. This gives the bench the exact final counter value and the exact number of events to expect.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int CTRL_W   = 32;
    localparam int PSC_W    = 8;
    localparam int PSC_LSB  = 8;

    localparam int OFF_CNT  = 'h00;
    localparam int OFF_CTRL = 'h08;
    localparam int OFF_STAT = 'h0C;
    localparam int OFF_CMP  = 'h10;
    localparam int OFF_STEP = 'h18;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             periodic;
        logic             irq_en;
        logic             cmp_en;
        logic             run;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.psc      = w[PSC_LSB +: PSC_W];
        c.periodic = w[3];
        c.irq_en   = w[2];
        c.cmp_en   = w[1];
        c.run      = w[0];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[PSC_LSB +: PSC_W] = c.psc;
        w[3] = c.periodic;
        w[2] = c.irq_en;
        w[1] = c.cmp_en;
        w[0] = c.run;
        return w;
    endfunction
endpackage

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   tick;

    always_comb begin
        st_d = st_q;
        tick = run_i && (st_q.cnt >= div_i);
        if (!run_i || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = tick;

    // R3: with a nonzero divider, two ticks are never back to back
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_i != '0 && run_i) |=> !tick_o);

    // R3: a stopped timer produces no ticks
    assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    localparam int NW    = CNT_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NW-1:0]     wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cnt_nxt_o,
    output logic              adv_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
        for (int w = 0; w < NW; w++) begin
            if (wr_i[w]) st_d.cnt[w*WORD_W +: WORD_W] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
    assign adv_o     = tick_i && (wr_i == '0);

    // R2: a counter that is neither ticking nor written keeps its value
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && wr_i == '0) |=> $stable(cnt_o));

    // R4: a tick advances the whole 64-bit value by exactly one
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && wr_i == '0) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/cmp_timer_compare.sv
module cmp_timer_compare #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32,
    localparam int NW    = CNT_W / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [CNT_W-1:0]  cnt_nxt_i,
    input  logic              cmp_en_i,
    input  logic              periodic_i,
    input  logic [NW-1:0]     cmp_wr_i,
    input  logic              step_wr_i,
    input  logic              clr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [WORD_W-1:0] step_o,
    output logic              flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [WORD_W-1:0] step;
        logic              flag;
    } state_t;

    state_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d = st_q;
        hit  = cmp_en_i && adv_i && (cnt_nxt_i == st_q.cmp);
        if (hit && periodic_i) begin
            st_d.cmp = st_q.cmp + {{(CNT_W-WORD_W){1'b0}}, st_q.step};
        end
        for (int w = 0; w < NW; w++) begin
            if (cmp_wr_i[w]) st_d.cmp[w*WORD_W +: WORD_W] = wdata_i;
        end
        if (step_wr_i) st_d.step = wdata_i;
        if (clr_i)     st_d.flag = 1'b0;
        if (hit)       st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o  = st_q.cmp;
    assign step_o = st_q.step;
    assign flag_o = st_q.flag;

    // R5: no event without compare enable
    assert_no_event_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en_i && !flag_o) |=> !flag_o);

    // R6: the flag stays set until a clear is written
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R8: one-shot hits leave the compare value alone
    assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !periodic_i && cmp_wr_i == '0) |=> $stable(cmp_o));

    // R9: periodic hits advance the compare value by the step
    assert_auto_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && periodic_i && cmp_wr_i == '0) |=>
        cmp_o == $past(cmp_o) + {{(CNT_W-WORD_W){1'b0}}, $past(step_o)});
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int NW = CNT_W / WORD_W;
    localparam int WB = WORD_W / 8;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NW-1:0]     cnt_wr, cmp_wr;
    logic              step_wr, clr;
    logic              tick, adv, flag;
    logic [CNT_W-1:0]  cnt, cnt_nxt, cmp;
    logic [WORD_W-1:0] step;

    function automatic logic at(input int off);
        return bus_addr == ADDR_W'(off);
    endfunction

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            cnt_wr[w] = bus_we && at(OFF_CNT + w*WB);
            cmp_wr[w] = bus_we && at(OFF_CMP + w*WB);
        end
        step_wr = bus_we && at(OFF_STEP);
        clr     = bus_we && at(OFF_STAT) && bus_wdata[0];
    end

    always_comb begin
        st_d = st_q;
        if (bus_we && at(OFF_CTRL)) st_d.ctrl = ctrl_unpack(bus_wdata);
        st_d.rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (at(OFF_CNT + w*WB)) st_d.rdata = cnt[w*WORD_W +: WORD_W];
            if (at(OFF_CMP + w*WB)) st_d.rdata = cmp[w*WORD_W +: WORD_W];
        end
        if (at(OFF_CTRL)) st_d.rdata = ctrl_pack(st_q.ctrl);
        if (at(OFF_STAT)) st_d.rdata = {{(WORD_W-1){1'b0}}, flag};
        if (at(OFF_STEP)) st_d.rdata = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cmp_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.ctrl.run),
        .div_i  (st_q.ctrl.psc),
        .tick_o (tick)
    );

    cmp_timer_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_i      (cnt_wr),
        .wdata_i   (bus_wdata),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .adv_o     (adv)
    );

    cmp_timer_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .cnt_nxt_i  (cnt_nxt),
        .cmp_en_i   (st_q.ctrl.cmp_en),
        .periodic_i (st_q.ctrl.periodic),
        .cmp_wr_i   (cmp_wr),
        .step_wr_i  (step_wr),
        .clr_i      (clr),
        .wdata_i    (bus_wdata),
        .cmp_o      (cmp),
        .step_o     (step),
        .flag_o     (flag)
    );

    assign bus_rdata = st_q.rdata;
    assign irq_o     = flag && st_q.ctrl.irq_en;

    // R7: the interrupt never rises while interrupts are masked
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.irq_en |-> !irq_o);

    // R3: a stopped timer keeps the counter still unless it is written
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && cnt_wr == '0) |=> $stable(cnt));
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic rd64(input logic [4:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 5'd4, hi);
        d = {hi, lo};
    endtask

    task automatic set64(input logic [4:0] a, input logic [63:0] v);
        wr(a, v[31:0]);
        wr(a + 5'd4, v[63:32]);
    endtask

    task automatic run_for(input logic [31:0] on, input logic [31:0] off, input int k);
        wr(5'h08, on);
        repeat (k) @(negedge clk);
        wr(5'h08, off);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(5'(a*4), d);
            chk("R1 reset value", {32'b0, d}, 64'd0);
        end
        chk("R1 irq after reset", {63'b0, irq_o}, 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] v;
        set64(5'h00, 64'h0000_0002_0000_0010);
        repeat (6) @(negedge clk);
        rd64(5'h00, v);
        chk("R2 counter written while stopped holds", v, 64'h0000_0002_0000_0010);
    endtask

    task automatic t_count();
        logic [63:0] v;
        set64(5'h00, 64'd0);
        run_for(32'h0000_0001, 32'h0, 9);
        rd64(5'h00, v);
        chk("R3 prescale 0 counts every clock", v, 64'd10);
        set64(5'h00, 64'd0);
        run_for(32'h0000_0301, 32'h0000_0300, 11);
        rd64(5'h00, v);
        chk("R3 prescale 3 counts every 4 clocks", v, 64'd3);
    endtask

    task automatic t_carry();
        logic [63:0] v;
        logic [31:0] s;
        wr(5'h0C, 32'h1);
        set64(5'h00, 64'h0000_0000_FFFF_FFFE);
        set64(5'h10, 64'h0000_0001_0000_0000);
        run_for(32'h0000_0003, 32'h0000_0002, 3);
        rd64(5'h00, v);
        chk("R4 carry into upper word", v, 64'h0000_0001_0000_0002);
        rd(5'h0C, s);
        chk("R5 full 64-bit match sets flag", {32'b0, s}, 64'd1);
    endtask

    task automatic t_one_shot();
        logic [63:0] v;
        logic [31:0] s;
        wr(5'h0C, 32'h1);
        set64(5'h00, 64'd0);
        set64(5'h10, 64'd5);
        run_for(32'h0000_0007, 32'h0000_0006, 9);
        rd(5'h0C, s);
        chk("R6 event sets flag", {32'b0, s}, 64'd1);
        chk("R7 irq with flag and enable", {63'b0, irq_o}, 64'd1);
        rd64(5'h10, v);
        chk("R8 one-shot leaves compare value", v, 64'd5);
        rd64(5'h00, v);
        chk("R8 counter keeps running past the hit", v, 64'd10);
        wr(5'h0C, 32'h0);
        rd(5'h0C, s);
        chk("R6 writing 0 keeps flag", {32'b0, s}, 64'd1);
        wr(5'h0C, 32'h1);
        rd(5'h0C, s);
        chk("R6 writing 1 clears flag", {32'b0, s}, 64'd0);
        chk("R7 irq falls with flag", {63'b0, irq_o}, 64'd0);
    endtask

    task automatic t_irq_mask();
        logic [31:0] s;
        set64(5'h00, 64'd0);
        set64(5'h10, 64'd2);
        run_for(32'h0000_0003, 32'h0000_0002, 5);
        rd(5'h0C, s);
        chk("R7 flag sets with irq masked", {32'b0, s}, 64'd1);
        chk("R7 irq stays low while masked", {63'b0, irq_o}, 64'd0);
        wr(5'h08, 32'h0000_0006);
        chk("R7 irq rises when unmasked", {63'b0, irq_o}, 64'd1);
        wr(5'h08, 32'h0);
        chk("R7 irq falls when masked again", {63'b0, irq_o}, 64'd0);
        wr(5'h0C, 32'h1);
    endtask

    task automatic t_no_event();
        logic [31:0] s;
        set64(5'h00, 64'd0);
        set64(5'h10, 64'd3);
        run_for(32'h0000_0001, 32'h0, 5);
        rd(5'h0C, s);
        chk("R5 no event with compare disabled", {32'b0, s}, 64'd0);
        wr(5'h08, 32'h0000_0002);
        set64(5'h00, 64'd3);
        rd(5'h0C, s);
        chk("R5 counter write onto compare value raises no event", {32'b0, s}, 64'd0);
        wr(5'h08, 32'h0);
    endtask

    task automatic t_periodic();
        logic [63:0] v;
        logic [31:0] s;
        set64(5'h00, 64'd0);
        set64(5'h10, 64'd4);
        wr(5'h18, 32'd10);
        run_for(32'h0000_000B, 32'h0000_000A, 25);
        rd64(5'h10, v);
        chk("R9 three hits advance compare by 3 steps", v, 64'd34);
        rd64(5'h00, v);
        chk("R9 counter runs through the hits", v, 64'd26);
        rd(5'h0C, s);
        chk("R9 periodic hits set flag", {32'b0, s}, 64'd1);
        wr(5'h0C, 32'h1);
        set64(5'h00, 64'hFFFF_FFFF_FFFF_FFFD);
        set64(5'h10, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(5'h18, 32'd5);
        run_for(32'h0000_000B, 32'h0000_000A, 0);
        rd64(5'h10, v);
        chk("R9 compare addition wraps", v, 64'd3);
        rd64(5'h00, v);
        chk("R9 counter at hit value", v, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(5'h0C, 32'h1);
        wr(5'h08, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(5'h08, 32'hFFFF_00F0);
        rd(5'h08, d);
        chk("R10 reserved control bits read zero", {32'b0, d}, 64'd0);
        wr(5'h08, 32'h0000_AB00);
        rd(5'h08, d);
        chk("R10 prescale field round trip", {32'b0, d}, 64'h0000_AB00);
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFE);
        rd(5'h0C, d);
        chk("R10 status upper bits read zero", {32'b0, d}, 64'd0);
        wr(5'h1C, 32'h1234_5678);
        rd(5'h1C, d);
        chk("R10 unmapped offset reads zero", {32'b0, d}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_count();
        t_carry();
        t_one_shot();
        t_irq_mask();
        t_no_event();
        t_periodic();
        t_reserved();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule